// File: doc/BRIEF.md
# Reference Clock Divider with Selectable Comparison Taps

This block turns a reference clock into the comparison pulses for two phase detectors of a frequency synthesizer. A programmable first stage divides the reference clock by a ratio R. A chain of four halving stages follows it. Together they give five candidate comparison rates: one pulse every R, 2R, 4R, 8R or 16R reference cycles. Two independent 3-bit selectors each pick one of the five taps. One selector feeds the main detector and the other feeds the auxiliary detector. Each output is a pulse one reference clock wide, so a detector can take it directly as an event.

All deeper taps are aligned to the first-stage pulse that ends their period. Two outputs on different taps therefore fire in the same cycle whenever the deeper one fires. When the power enable drops, both outputs go quiet and every counter returns to zero. When the enable rises again, the pulse train restarts from a known phase, exactly as it does after reset. A synthesizer can then restart its main divider on the same edge and avoid a random initial phase.

Top module: `ref_tap_divider`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both outputs are 0, whatever the power enable and the selectors are.
- R2: Let the power enable be raised so that cycle 0 is the first cycle with it high, and let Reff be the effective ratio. With tap 0 selected, the output is high exactly in cycles c > 0 where c mod Reff = 0, for one cycle each time.
- R3: Tap k (k = 0 to 4) is high exactly in cycles c > 0 where c mod (2^k * Reff) = 0. Every tap-k pulse therefore coincides with a pulse of every shallower tap.
- R4: The main selector code, read as a binary value 0 to 4, chooses tap k = code for the main output. Code 0 is the undivided rate and code 4 is the 16x rate.
- R5: The auxiliary selector chooses its tap the same way, independently of the main selector. When both selectors choose the same tap, both outputs are equal in every cycle.
- R6: Selector codes 5, 6 and 7 behave exactly like code 4, the deepest tap.
- R7: A ratio value below 4 (0 to 3) acts as 4. Values 4 to 1023 are used as given.
- R8: When the power enable is low at a clock edge, both outputs are 0 in the following cycle and all counters are cleared. The next power-up reproduces the pulse timing of R2 and R3 from its own cycle 0.
- R9: The maximum ratio 1023 gives tap 0 pulses at cycle 1023 and tap 4 pulses at cycle 16368.
- R10: A selector change made during cycle c takes effect for the output of cycle c+1. Every output pulse is one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous reset, active low |
| powerEn | input | 1 | Divider enable; low holds the divider cleared and quiet |
| ratio | input | 10 | Programmable first-stage ratio R |
| mainSel | input | 3 | Tap code for the main detector output |
| auxSel | input | 3 | Tap code for the auxiliary detector output |
| mainTick | output | 1 | Selected comparison pulse for the main detector |
| auxTick | output | 1 | Selected comparison pulse for the auxiliary detector |

## Verification
Two things can land in the same cycle: pulses of both outputs, and a selector change that meets a pulse edge. Coincidence is provoked by putting the two selectors on nested taps. The bench then counts the cycles where both outputs are high and compares that count with the number of deep-tap periods. Selector changes are made mid-run, and each sampled cycle is judged against the selector value that was in force one cycle earlier. Power-down in the middle of a count is followed by a fresh start, which must reproduce the from-zero timing.

// File: rtl/ref_tap_pkg.sv
package ref_tap_pkg;
  // Number of halving stages after the programmable divider.
  localparam int CHAIN_STAGES = 4;
  // One tap after the first stage, plus one after each halving stage.
  localparam int TAP_COUNT    = CHAIN_STAGES + 1;

  // Strobes passed from the counting control to the tap datapath.
  typedef struct packed {
    logic                    run;       // divider enabled this cycle
    logic                    primTick;  // first-stage terminal count
    logic [CHAIN_STAGES-1:0] chain;     // halving chain state
  } refStrobe_t;
endpackage

// File: rtl/ref_tap_ctrl.sv
module ref_tap_ctrl
  import ref_tap_pkg::*;
#(
  parameter int RATIO_W   = 10,
  parameter int MIN_RATIO = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               powerEn,
  input  logic [RATIO_W-1:0] ratio,
  output refStrobe_t         strobe
);
  localparam logic [RATIO_W-1:0] MIN_V = RATIO_W'(MIN_RATIO);
  localparam logic [RATIO_W-1:0] ONE_V = RATIO_W'(1);

  logic [RATIO_W-1:0]      effRatio;
  logic [RATIO_W-1:0]      lastCount;
  logic [RATIO_W-1:0]      rCnt;
  logic [CHAIN_STAGES-1:0] chain;
  logic                    primTick;

  // Ratios below the minimum are raised to it.
  always_comb begin
    effRatio  = (ratio < MIN_V) ? MIN_V : ratio;
    lastCount = effRatio - ONE_V;
  end

  // A ratio change while running can leave rCnt above the new limit,
  // so the terminal test uses >= and the count wraps at once.
  assign primTick = powerEn && (rCnt >= lastCount);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rCnt <= '0;
    end else if (!powerEn) begin
      rCnt <= '0;
    end else if (primTick) begin
      rCnt <= '0;
    end else begin
      rCnt <= rCnt + ONE_V;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else if (!powerEn) begin
      chain <= '0;
    end else if (primTick) begin
      chain <= chain + CHAIN_STAGES'(1);
    end
  end

  assign strobe.run      = powerEn;
  assign strobe.primTick = primTick;
  assign strobe.chain    = chain;

  // R7: the terminal count is never reached below the minimum ratio.
  a_r7_min_ratio: assert property (@(posedge clk) disable iff (!rstN)
    primTick |-> (rCnt >= MIN_V - ONE_V));

  // R3: the chain advances by one on each first-stage pulse.
  a_r3_chain_step: assert property (@(posedge clk) disable iff (!rstN)
    primTick |=> (chain == $past(chain) + CHAIN_STAGES'(1)));

  // R3: the chain holds between first-stage pulses.
  a_r3_chain_hold: assert property (@(posedge clk) disable iff (!rstN)
    (powerEn && !primTick) |=> $stable(chain));

  // R8: power-down clears every counter.
  a_r8_cleared: assert property (@(posedge clk) disable iff (!rstN)
    !powerEn |=> (rCnt == '0 && chain == '0));
endmodule

// File: rtl/ref_tap_path.sv
module ref_tap_path
  import ref_tap_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  refStrobe_t       strobe,
  input  logic [SEL_W-1:0] mainSel,
  input  logic [SEL_W-1:0] auxSel,
  output logic             mainTick,
  output logic             auxTick
);
  localparam logic [SEL_W-1:0] DEEPEST = SEL_W'(TAP_COUNT - 1);

  logic [TAP_COUNT-1:0] tap;
  logic [SEL_W-1:0]     mainIdx;
  logic [SEL_W-1:0]     auxIdx;

  // Tap k fires on the first-stage pulse that completes 2^k first-stage periods.
  for (genvar k = 0; k < TAP_COUNT; k++) begin : g_tap
    if (k == 0) begin : g_first
      assign tap[k] = strobe.primTick;
    end else begin : g_deep
      assign tap[k] = strobe.primTick && (&strobe.chain[k-1:0]);
    end
  end

  // Codes past the deepest tap choose the deepest tap.
  always_comb begin
    mainIdx = (mainSel > DEEPEST) ? DEEPEST : mainSel;
    auxIdx  = (auxSel  > DEEPEST) ? DEEPEST : auxSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainTick <= 1'b0;
      auxTick  <= 1'b0;
    end else if (!strobe.run) begin
      mainTick <= 1'b0;
      auxTick  <= 1'b0;
    end else begin
      mainTick <= tap[mainIdx];
      auxTick  <= tap[auxIdx];
    end
  end

  // R8: no output pulse in the cycle after a disabled edge.
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.run |=> (!mainTick && !auxTick));

  // R10: main output pulses are one cycle wide.
  a_r10_main_single: assert property (@(posedge clk) disable iff (!rstN)
    mainTick |=> !mainTick);

  // R10: auxiliary output pulses are one cycle wide.
  a_r10_aux_single: assert property (@(posedge clk) disable iff (!rstN)
    auxTick |=> !auxTick);

  // R5: equal selections give equal outputs.
  a_r5_same_tap: assert property (@(posedge clk) disable iff (!rstN)
    (mainSel == auxSel) |=> (mainTick == auxTick));
endmodule

// File: rtl/ref_tap_divider.sv
module ref_tap_divider
  import ref_tap_pkg::*;
#(
  parameter int RATIO_W   = 10,
  parameter int SEL_W     = 3,
  parameter int MIN_RATIO = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               powerEn,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [SEL_W-1:0]   mainSel,
  input  logic [SEL_W-1:0]   auxSel,
  output logic               mainTick,
  output logic               auxTick
);
  refStrobe_t strobe;

  ref_tap_ctrl #(
    .RATIO_W  (RATIO_W),
    .MIN_RATIO(MIN_RATIO)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .powerEn(powerEn),
    .ratio  (ratio),
    .strobe (strobe)
  );

  ref_tap_path #(
    .SEL_W(SEL_W)
  ) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .mainSel (mainSel),
    .auxSel  (auxSel),
    .mainTick(mainTick),
    .auxTick (auxTick)
  );
endmodule

// File: tb/sim_ref_tap_divider.sv
module sim_ref_tap_divider;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       powerEn = 1'b0;
  logic [9:0] ratio = 10'd4;
  logic [2:0] mainSel = 3'd0;
  logic [2:0] auxSel = 3'd0;
  logic       mainTick;
  logic       auxTick;

  int testsRun = 0;
  int testsFailed = 0;
  int bothCount = 0;

  ref_tap_divider u0 (
    .clk(clk), .rstN(rstN), .powerEn(powerEn), .ratio(ratio),
    .mainSel(mainSel), .auxSel(auxSel), .mainTick(mainTick), .auxTick(auxTick)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit expTick(input int c, input int effR, input int sel);
    int k;
    k = (sel > 4) ? 4 : sel;
    return (c > 0) && ((c % (effR << k)) == 0);
  endfunction

  // Power cycle, then compare every cycle; mismatches are folded into one check.
  task automatic runCase(input int rat, input int mS, input int aS, input int n,
                         input int chgAt, input int mS2, input string req);
    int effR, bad, firstC, actV, expV, prevM, prevA;
    effR = (rat < 4) ? 4 : rat;
    bad = 0; firstC = -1; actV = 0; expV = 0; bothCount = 0;
    @(negedge clk);
    powerEn = 1'b0;
    ratio = rat[9:0];
    mainSel = mS[2:0];
    auxSel = aS[2:0];
    repeat (2) @(negedge clk);
    powerEn = 1'b1;
    prevM = mS; prevA = aS;
    for (int c = 1; c <= n; c++) begin
      @(negedge clk);
      if (mainTick != expTick(c, effR, prevM) || auxTick != expTick(c, effR, prevA)) begin
        if (bad == 0) begin
          firstC = c;
          actV = {mainTick, auxTick};
          expV = {expTick(c, effR, prevM), expTick(c, effR, prevA)};
        end
        bad++;
      end
      if (mainTick && auxTick) bothCount++;
      if (c == chgAt) mainSel = mS2[2:0];
      prevM = mainSel;
      prevA = auxSel;
    end
    if (bad != 0) $display("  %s first mismatch at cycle %0d (bits main,aux)", req, firstC);
    check(bad == 0, req, actV, expV);
  endtask

  task automatic testReset();
    rstN = 1'b0; powerEn = 1'b1; ratio = 10'd4; mainSel = 3'd0; auxSel = 3'd0;
    repeat (6) begin
      @(negedge clk);
      check(!mainTick && !auxTick, "R1 reset outputs", {mainTick, auxTick}, 0);
    end
    rstN = 1'b1;
    @(negedge clk);
    check(!mainTick && !auxTick, "R1 first cycle after reset", {mainTick, auxTick}, 0);
  endtask

  task automatic testBaseTaps();
    runCase(6, 0, 1, 200, -1, 0, "R2 tap0/tap1 ratio 6");
    runCase(5, 2, 3, 400, -1, 0, "R3 tap2/tap3 ratio 5");
    check(bothCount == 10, "R3 coincident pulses", bothCount, 10);
    runCase(4, 4, 0, 300, -1, 0, "R4 main deepest, R5 aux tap0");
    runCase(9, 3, 3, 300, -1, 0, "R5 equal selections");
  endtask

  task automatic testHighCodes();
    runCase(4, 7, 5, 300, -1, 0, "R6 codes 7 and 5 act as 4");
    runCase(4, 6, 4, 300, -1, 0, "R6 code 6 acts as 4");
    check(bothCount == 300 / 64, "R6 code 6 matches code 4", bothCount, 300 / 64);
  endtask

  task automatic testClamp();
    runCase(1, 0, 1, 100, -1, 0, "R7 ratio 1 acts as 4");
    runCase(0, 0, 2, 100, -1, 0, "R7 ratio 0 acts as 4");
    runCase(3, 1, 0, 100, -1, 0, "R7 ratio 3 acts as 4");
  endtask

  task automatic testPowerDown();
    runCase(7, 1, 0, 30, -1, 0, "R8 run before power-down");
    @(negedge clk);
    powerEn = 1'b0;
    repeat (5) begin
      @(negedge clk);
      check(!mainTick && !auxTick, "R8 quiet while down", {mainTick, auxTick}, 0);
    end
    // runCase keeps the enable low, then raises it: fresh timing expected.
    runCase(7, 1, 0, 120, -1, 0, "R8 restart timing");
  endtask

  task automatic testMaxRatio();
    runCase(1023, 0, 4, 16370, -1, 0, "R9 ratio 1023");
    check(bothCount == 1, "R9 one deep pulse", bothCount, 1);
  endtask

  task automatic testSelChange();
    runCase(4, 0, 2, 200, 37, 3, "R10 main selector change mid-run");
    runCase(4, 3, 1, 200, 64, 0, "R10 change at a pulse cycle");
  endtask

  initial begin
    #(200000 * 10);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    testReset();
    testBaseTaps();
    testHighCodes();
    testClamp();
    testPowerDown();
    testMaxRatio();
    testSelChange();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule